// File: doc/BRIEF.md
# Power-Management Interrupt and Wake Aggregator

This block merges interrupt requests from eight peripheral functions, plus one optional keyboard-controller port bit, into a single active-low system-management interrupt. The merged interrupt reaches two outputs. The dedicated pin is controlled by a pin-enable bit. A second output stands in for the serial/parallel IRQ route and is controlled by a route bit. Every request latches a sticky status bit, whether or not that source is enabled. Software clears a status bit by writing 1 to it.

The block also merges wake events into one active-low power-management-event output. The wake events are falling edges on two ring-indicator inputs, falling edges on the keyboard clock, falling edges on the mouse clock, and a pulse from an external remote-control frame decoder. The four pin sources are asynchronous. Each passes through a two-flop synchronizer before edge detection. Each detected event sets a sticky wake status bit. The output asserts while any enabled status bit is set, provided the global wake enable is on.

Software reaches six byte-wide registers through a simple address/write-data/read-data bus. Writes are registered on the rising clock edge. Reads are combinational.

Top module: `pm_irq_wake_agg`

## Requirements
- R1: `smi_n` is low exactly when IRQ_EN_B bit 7 is 1 and at least one source has both its request and its enable high. The enables are IRQ_EN_A (offset 0) bit i for `irq_req[i]`, i = 0..6, IRQ_EN_B (offset 1) bit 0 for `irq_req[7]`, and IRQ_EN_B bit 1 for `kbc_req`. `smi_n` responds combinationally to the requests.
- R2: A high `irq_req[i]` or `kbc_req` on a rising edge sets its status bit, whether or not that source is enabled. The status bits are IRQ_ST_A (offset 2) bit i for i = 0..6, IRQ_ST_B (offset 3) bit 0 for `irq_req[7]`, and IRQ_ST_B bit 1 for `kbc_req`.
- R3: Interrupt and wake status bits clear when software writes 1 to that bit position. Writing 0 leaves a bit unchanged. A request active in the same cycle as the clearing write wins, and the bit stays set.
- R4: `alt_smi_n` is low exactly when IRQ_EN_B bit 6 is 1 and the merged interrupt is active. It does not depend on bit 7.
- R5: The keyboard-controller port bit `kbc_req` acts as an extra source. It is enabled by IRQ_EN_B bit 1 and its status is IRQ_ST_B bit 1.
- R6: A falling edge on `ri1_n`, `ri2_n`, `kbd_clk` or `mse_clk` sets WAKE_ST (offset 5) bit 0, 1, 3 or 4 respectively. The bit is set on the third rising clock edge after the input falls. Rising edges set nothing.
- R7: A high `frame_ok` on a rising edge sets WAKE_ST bit 2 on that edge.
- R8: `pme_n` is low exactly when WAKE_EN (offset 4) bit 7 is 1 and some WAKE_ST bit is set together with the same WAKE_EN bit (bits 0..4). A wake status bit is still set when its enable is 0.
- R9: With WAKE_EN bit 7 at 0, `pme_n` stays high whatever the wake status and the per-source enables.
- R10: After reset every register reads 0 and `smi_n`, `alt_smi_n` and `pme_n` are high.
- R11: Offsets 6 and 7 read 0, and writes to them change nothing.
- R12: Register readback behaves as follows.
  - IRQ_EN_B returns all 8 written bits.
  - IRQ_EN_A returns bits 6..0, and bit 7 reads 0.
  - WAKE_EN returns bits 7 and 4..0, and bits 6..5 read 0.
  - IRQ_ST_B bits 7..2 read 0.
  - IRQ_ST_A bit 7 reads 0.
  - WAKE_ST bits 7..5 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, registered on the rising edge |
| rdata | output | 8 | Combinational read data for `addr` |
| irq_req | input | 8 | Requests: 0 parallel, 1 serial 2, 2 serial 1, 3 floppy, 4 watchdog, 5 mouse, 6 keyboard, 7 infrared |
| kbc_req | input | 1 | Keyboard-controller port bit used as an extra source |
| ri1_n | input | 1 | Ring indicator 1, asynchronous |
| ri2_n | input | 1 | Ring indicator 2, asynchronous |
| kbd_clk | input | 1 | Keyboard clock, asynchronous |
| mse_clk | input | 1 | Mouse clock, asynchronous |
| frame_ok | input | 1 | Valid remote-frame pulse, synchronous |
| smi_n | output | 1 | Merged interrupt, dedicated pin, active low |
| alt_smi_n | output | 1 | Merged interrupt, alternate route, active low |
| pme_n | output | 1 | Power-management event, active low |

## Verification
The assertions check four things on every cycle:
- An active request is always latched into status on the next edge.
- A clearing write with no active request leaves exactly the unwritten bits.
- Wake status never drops without a write.
- A cleared global wake enable always holds `pme_n` high.

The edge detectors are also checked never to pulse on two consecutive cycles. The directed scenarios are needed for the rest:
- the exact three-edge latency from an asynchronous wake input to status;
- that rising edges set nothing;
- the independence of the two interrupt routes;
- register readback masks;
- that the unused offsets ignore writes.

// File: rtl/pmw_pkg.sv
package pmw_pkg;
    localparam int REG_W   = 8;
    localparam int ADDR_W  = 3;
    localparam int N_REQ   = 8;
    localparam int N_LOW   = N_REQ - 1;
    localparam int N_WAKE  = 5;
    localparam int N_PINS  = 4;
    localparam int SYNC_ST = 2;

    localparam logic [ADDR_W-1:0] OFS_EN_A  = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_EN_B  = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_ST_A  = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_ST_B  = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_WEN   = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_WST   = 3'd5;

    localparam int ENB_IR    = 0;
    localparam int ENB_KBC   = 1;
    localparam int ENB_ROUTE = 6;
    localparam int ENB_PIN   = 7;

    typedef struct packed {
        logic [N_LOW-1:0] en_a;
        logic [REG_W-1:0] en_b;
        logic [N_LOW-1:0] st_a;
        logic [1:0]       st_b;
    } irq_state_t;

    typedef struct packed {
        logic [N_WAKE-1:0] wen;
        logic              glob;
        logic [N_WAKE-1:0] wst;
    } wake_state_t;
endpackage

// File: rtl/pmw_sync_edge.sv
module pmw_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall
);
    logic [STAGES-1:0] sh_d, sh_q;
    logic              prev_d, prev_q;

    always_comb begin
        sh_d   = {sh_q[STAGES-2:0], din};
        prev_d = sh_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '1;
            prev_q <= 1'b1;
        end else begin
            sh_q   <= sh_d;
            prev_q <= prev_d;
        end
    end

    assign fall = prev_q & ~sh_q[STAGES-1];

    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/pmw_irq_regs.sv
module pmw_irq_regs
    import pmw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] irq_req,
    input  logic             kbc_req,
    input  logic             wr_en_a,
    input  logic             wr_en_b,
    input  logic             wr_st_a,
    input  logic             wr_st_b,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] en_a_rd,
    output logic [REG_W-1:0] en_b_rd,
    output logic [REG_W-1:0] st_a_rd,
    output logic [REG_W-1:0] st_b_rd,
    output logic             smi_n,
    output logic             alt_smi_n
);
    irq_state_t s_d, s_q;
    logic       grp;

    always_comb begin
        s_d = s_q;
        if (wr_en_a) s_d.en_a = wdata[N_LOW-1:0];
        if (wr_en_b) s_d.en_b = wdata;
        if (wr_st_a) s_d.st_a = s_q.st_a & ~wdata[N_LOW-1:0];
        if (wr_st_b) s_d.st_b = s_q.st_b & ~wdata[1:0];
        s_d.st_a = s_d.st_a | irq_req[N_LOW-1:0];
        s_d.st_b = s_d.st_b | {kbc_req, irq_req[N_REQ-1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        grp = (|(s_q.en_a & irq_req[N_LOW-1:0]))
            | (s_q.en_b[ENB_IR]  & irq_req[N_REQ-1])
            | (s_q.en_b[ENB_KBC] & kbc_req);
        smi_n     = ~(grp & s_q.en_b[ENB_PIN]);
        alt_smi_n = ~(grp & s_q.en_b[ENB_ROUTE]);
        en_a_rd   = {1'b0, s_q.en_a};
        en_b_rd   = s_q.en_b;
        st_a_rd   = {1'b0, s_q.st_a};
        st_b_rd   = {6'd0, s_q.st_b};
    end

    // R2
    req_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req != '0 || kbc_req) |=>
        ((s_q.st_a & $past(irq_req[N_LOW-1:0])) == $past(irq_req[N_LOW-1:0])) &&
        ((s_q.st_b & $past({kbc_req, irq_req[N_REQ-1]})) == $past({kbc_req, irq_req[N_REQ-1]})));

    // R3
    w1c_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_st_a && irq_req[N_LOW-1:0] == '0) |=>
        s_q.st_a == ($past(s_q.st_a) & ~$past(wdata[N_LOW-1:0])));

    // R1
    idle_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req == '0 && !kbc_req) |-> (smi_n && alt_smi_n));
endmodule

// File: rtl/pmw_wake_regs.sv
module pmw_wake_regs
    import pmw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_WAKE-1:0] evt,
    input  logic              wr_wen,
    input  logic              wr_wst,
    input  logic [N_WAKE-1:0] wbits,
    input  logic              wglob,
    output logic [REG_W-1:0]  wen_rd,
    output logic [REG_W-1:0]  wst_rd,
    output logic              pme_n
);
    wake_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_wen) begin
            s_d.wen  = wbits;
            s_d.glob = wglob;
        end
        if (wr_wst) s_d.wst = s_q.wst & ~wbits;
        s_d.wst = s_d.wst | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        pme_n  = ~(s_q.glob & (|(s_q.wst & s_q.wen)));
        wen_rd = {s_q.glob, 2'b00, s_q.wen};
        wst_rd = {3'b000, s_q.wst};
    end

    // R9
    global_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.glob |-> pme_n);

    // R6
    sticky_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_wst |=> ($past(s_q.wst) & ~s_q.wst) == '0);
endmodule

// File: rtl/pm_irq_wake_agg.sv
module pm_irq_wake_agg
    import pmw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              wr_en,
    output logic [REG_W-1:0]  rdata,
    input  logic [N_REQ-1:0]  irq_req,
    input  logic              kbc_req,
    input  logic              ri1_n,
    input  logic              ri2_n,
    input  logic              kbd_clk,
    input  logic              mse_clk,
    input  logic              frame_ok,
    output logic              smi_n,
    output logic              alt_smi_n,
    output logic              pme_n
);
    logic [N_PINS-1:0] pin_raw, pin_fall;
    logic [N_WAKE-1:0] evt;
    logic [REG_W-1:0]  en_a_rd, en_b_rd, st_a_rd, st_b_rd, wen_rd, wst_rd;

    assign pin_raw = {mse_clk, kbd_clk, ri2_n, ri1_n};

    for (genvar g = 0; g < N_PINS; g++) begin : g_sync
        pmw_sync_edge #(.STAGES(SYNC_ST)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (pin_raw[g]),
            .fall (pin_fall[g])
        );
    end

    assign evt = {pin_fall[3], pin_fall[2], frame_ok, pin_fall[1], pin_fall[0]};

    pmw_irq_regs u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_req  (irq_req),
        .kbc_req  (kbc_req),
        .wr_en_a  (wr_en && addr == OFS_EN_A),
        .wr_en_b  (wr_en && addr == OFS_EN_B),
        .wr_st_a  (wr_en && addr == OFS_ST_A),
        .wr_st_b  (wr_en && addr == OFS_ST_B),
        .wdata    (wdata),
        .en_a_rd  (en_a_rd),
        .en_b_rd  (en_b_rd),
        .st_a_rd  (st_a_rd),
        .st_b_rd  (st_b_rd),
        .smi_n    (smi_n),
        .alt_smi_n(alt_smi_n)
    );

    pmw_wake_regs u_wake (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .wr_wen(wr_en && addr == OFS_WEN),
        .wr_wst(wr_en && addr == OFS_WST),
        .wbits (wdata[N_WAKE-1:0]),
        .wglob (wdata[REG_W-1]),
        .wen_rd(wen_rd),
        .wst_rd(wst_rd),
        .pme_n (pme_n)
    );

    always_comb begin
        unique case (addr)
            OFS_EN_A: rdata = en_a_rd;
            OFS_EN_B: rdata = en_b_rd;
            OFS_ST_A: rdata = st_a_rd;
            OFS_ST_B: rdata = st_b_rd;
            OFS_WEN:  rdata = wen_rd;
            OFS_WST:  rdata = wst_rd;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: tb/pm_irq_wake_agg_bench.sv
module pm_irq_wake_agg_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0;
    logic [7:0] rdata;
    logic [7:0] irq_req = '0;
    logic       kbc_req = 1'b0;
    logic       ri1_n = 1'b1, ri2_n = 1'b1, kbd_clk = 1'b1, mse_clk = 1'b1;
    logic       frame_ok = 1'b0;
    logic       smi_n, alt_smi_n, pme_n;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    pm_irq_wake_agg u_pm_irq_wake_agg (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rdata(rdata), .irq_req(irq_req), .kbc_req(kbc_req), .ri1_n(ri1_n),
        .ri2_n(ri2_n), .kbd_clk(kbd_clk), .mse_clk(mse_clk), .frame_ok(frame_ok),
        .smi_n(smi_n), .alt_smi_n(alt_smi_n), .pme_n(pme_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
        addr = a; #1;
        chk(req, rdata, exp);
    endtask

    task automatic t_reset;
        for (int a = 0; a < 8; a++) rd_chk("R10 reg", 3'(a), 8'h00);
        chk("R10 pins", {5'd0, smi_n, alt_smi_n, pme_n}, 8'h07);
    endtask

    task automatic t_readback;
        wr(3'd0, 8'hFF); rd_chk("R12 en_a", 3'd0, 8'h7F);
        wr(3'd1, 8'h3C); rd_chk("R12 en_b", 3'd1, 8'h3C);
        wr(3'd4, 8'hFF); rd_chk("R12 wen", 3'd4, 8'h9F);
        wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd4, 8'h00);
    endtask

    task automatic t_unused;
        wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
        rd_chk("R11 ofs6", 3'd6, 8'h00);
        rd_chk("R11 ofs7", 3'd7, 8'h00);
        for (int a = 0; a < 6; a++) rd_chk("R11 others", 3'(a), 8'h00);
    endtask

    task automatic t_status_no_en;
        @(negedge clk); irq_req = 8'h08;
        #1 chk("R2 smi idle", {7'd0, smi_n}, 8'h01);
        @(negedge clk); irq_req = 8'h00;
        rd_chk("R2 st_a", 3'd2, 8'h08);
    endtask

    task automatic t_w1c;
        wr(3'd2, 8'h00); rd_chk("R3 write0", 3'd2, 8'h08);
        wr(3'd2, 8'h08); rd_chk("R3 write1", 3'd2, 8'h00);
        @(negedge clk); irq_req = 8'h08;
        wr(3'd2, 8'h08); rd_chk("R3 set wins", 3'd2, 8'h08);
        irq_req = 8'h00;
        wr(3'd2, 8'hFF); rd_chk("R3 cleared", 3'd2, 8'h00);
    endtask

    task automatic t_smi;
        wr(3'd0, 8'h04); wr(3'd1, 8'h80);
        @(negedge clk); irq_req = 8'h04; #1;
        chk("R1 smi on", {6'd0, smi_n, alt_smi_n}, 8'h01);
        irq_req = 8'h20; #1;
        chk("R1 not enabled", {7'd0, smi_n}, 8'h01);
        irq_req = 8'h04;
        wr(3'd1, 8'h00); #1;
        chk("R1 pin off", {7'd0, smi_n}, 8'h01);
        irq_req = 8'h00;
    endtask

    task automatic t_route;
        wr(3'd1, 8'h40);
        @(negedge clk); irq_req = 8'h04; #1;
        chk("R4 alt only", {6'd0, smi_n, alt_smi_n}, 8'h02);
        irq_req = 8'h00; #1;
        chk("R4 alt idle", {7'd0, alt_smi_n}, 8'h01);
        wr(3'd0, 8'h00); wr(3'd1, 8'h00);
        wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    endtask

    task automatic t_kbc;
        wr(3'd1, 8'h82);
        @(negedge clk); kbc_req = 1'b1; #1;
        chk("R5 smi", {7'd0, smi_n}, 8'h00);
        @(negedge clk); kbc_req = 1'b0;
        rd_chk("R5 st_b", 3'd3, 8'h02);
        @(negedge clk); irq_req = 8'h80; #1;
        chk("R1 ir not enabled", {7'd0, smi_n}, 8'h01);
        @(negedge clk); irq_req = 8'h00;
        rd_chk("R2 st_b ir", 3'd3, 8'h03);
        wr(3'd3, 8'hFF); wr(3'd1, 8'h00);
    endtask

    task automatic t_wake_edge;
        wr(3'd4, 8'h81);
        @(negedge clk); ri1_n = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R6 not yet", {7'd0, pme_n}, 8'h01);
        @(posedge clk); @(negedge clk);
        chk("R8 pme on", {7'd0, pme_n}, 8'h00);
        rd_chk("R6 wst ri1", 3'd5, 8'h01);
        wr(3'd5, 8'h01);
        ri1_n = 1'b1;
        repeat (5) @(negedge clk);
        rd_chk("R6 rise ignored", 3'd5, 8'h00);
        chk("R6 pme off", {7'd0, pme_n}, 8'h01);
        kbd_clk = 1'b0;
        repeat (4) @(negedge clk);
        rd_chk("R8 unenabled set", 3'd5, 8'h08);
        chk("R8 pme gated", {7'd0, pme_n}, 8'h01);
        kbd_clk = 1'b1;
        wr(3'd5, 8'hFF);
    endtask

    task automatic t_frame;
        @(negedge clk); frame_ok = 1'b1;
        @(negedge clk); frame_ok = 1'b0;
        rd_chk("R7 frame", 3'd5, 8'h04);
        wr(3'd5, 8'h04);
    endtask

    task automatic t_global;
        wr(3'd4, 8'h1F);
        mse_clk = 1'b0;
        repeat (4) @(negedge clk);
        rd_chk("R9 status", 3'd5, 8'h10);
        chk("R9 blocked", {7'd0, pme_n}, 8'h01);
        wr(3'd4, 8'h9F); #1;
        chk("R8 global on", {7'd0, pme_n}, 8'h00);
        mse_clk = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_unused();
        t_status_no_en();
        t_w1c();
        t_smi();
        t_route();
        t_kbc();
        t_wake_edge();
        t_frame();
        t_global();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule